// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block holds the control state a small processor core needs to enter and leave exception handlers: the program counter, the current status word, and one link register and one saved-status register for each privileged mode. Seven request sources compete for service: reset, undefined opcode, software trap, prefetch abort, data abort, normal interrupt and fast interrupt. The block picks one per clock. In that same edge it stores the old status word in the target mode's saved copy, writes the return address into that mode's link register, switches the mode field, sets the mask bits and loads the fixed handler address.

The instruction presented on `insn_bits_i` is the one at the current program counter. Its condition has already been evaluated upstream, so only bits 27:0 arrive. A software trap is decoded from the opcode nibble, and its 24-bit payload is kept as the trap number for the handler. A return request reloads the program counter from the current mode's link register and the status word from that mode's saved copy in one step. When no event occurs, a valid instruction advances the program counter by one word.

Top module: `exc_seq`

## Requirements
- R1: While `rst_n` is low, the outputs take these values:
  - `pc_o` is 0.
  - `psr_o` is 0x000000D3: mode field bits 4:0 = 10011 (supervisor), bit 7 (normal-interrupt mask) set, bit 6 (fast-interrupt mask) set.
  - Every saved status word is 0x00000010.
  - Every link register is 0.
  - `trap_num_o` is 0.
- R2: A taken exception loads the program counter with its handler address and sets the mode field as follows:

  | Exception | Handler address | Mode field |
  |---|---|---|
  | Reset | 0x00 | 10011 |
  | Undefined opcode | 0x04 | 11011 |
  | Software trap | 0x08 | 10011 |
  | Prefetch abort | 0x0C | 10111 |
  | Data abort | 0x10 | 10111 |
  | Normal interrupt | 0x18 | 10010 |
  | Fast interrupt | 0x1C | 10001 |

  User mode is 10000. The new values are visible after the next clock edge.
- R3: A software trap is recognised when `insn_valid_i` is high and `insn_bits_i[27:24]` is 1111. After the trap is taken, `trap_num_o` shows `insn_bits_i[23:0]` unchanged and holds it until the next trap is taken.
- R4: Every taken exception except reset writes two registers of the target mode:
  - the saved status word receives the status word from before entry;
  - the link register receives `pc_o` + 4.
  
  No other bank changes. Reset writes no bank.
- R5: On entry the mode field is replaced and bit 7 is set. Bit 6 is also set for fast interrupt and reset. All other status bits keep their value.
- R6: Priority among pending requests, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined opcode, software trap.
- R7: A normal-interrupt request has no effect while status bit 7 is set. A fast-interrupt request has no effect while status bit 6 is set.
- R8: With no exception taken, a return request in a privileged mode performs both of these updates together:
  - `pc_o` is loaded from that mode's link register with bits 1:0 cleared;
  - `psr_o` is loaded from that mode's saved status word.
- R9: A return request in user mode, with no exception taken, leaves `pc_o` and `psr_o` unchanged, even when `insn_valid_i` is high.
- R10: With no exception and no return, `pc_o` advances by 4 when `insn_valid_i` is high and holds otherwise. The status word does not change.
- R11: Each bank occupies its own slice of `lr_bank_o` and `spsr_bank_o`. Bank b sits at bits [b*W +: W], where W is the register width. The banks are:
  - 0: fast interrupt
  - 1: normal interrupt
  - 2: supervisor
  - 3: abort
  - 4: undefined
- R12: `pc_o[1:0]` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| rst_req_i | input | 1 | Reset exception request |
| und_req_i | input | 1 | Undefined-opcode request for the current instruction |
| pabt_req_i | input | 1 | Prefetch-abort request |
| dabt_req_i | input | 1 | Data-abort request |
| irq_req_i | input | 1 | Normal interrupt request (level) |
| fiq_req_i | input | 1 | Fast interrupt request (level) |
| insn_valid_i | input | 1 | Instruction at `pc_o` executes this cycle |
| insn_bits_i | input | 28 | Instruction bits 27:0 |
| ret_req_i | input | 1 | Exception-return request |
| pc_o | output | 32 | Program counter |
| psr_o | output | 32 | Current status word |
| lr_bank_o | output | 160 | Five banked link registers |
| spsr_bank_o | output | 160 | Five banked saved status words |
| trap_num_o | output | 24 | Payload of the last software trap taken |

## Verification
Some properties are checked by assertions on every cycle:
- a masked interrupt source is never selected;
- a reset request always lands in supervisor mode at address zero with both masks set, whatever else is pending;
- a software trap always lands at 0x08 in supervisor mode and fills the supervisor bank with the old status word and the address after the trap;
- a return restores the program counter and status word together;
- a user-mode return changes nothing;
- banks without a write enable hold their contents;
- the mode field only ever holds one of the six legal encodings.

Other behaviour depends on state built up across cycles, and only the bench scenarios show it:
- the full arbitration order over every combination of requests;
- masking from each of the three starting states;
- return chains after each kind of entry;
- slice placement of the banks;
- persistence of the trap number.

// File: rtl/exc_seq_pkg.sv
`timescale 1ns/1ps
package exc_seq_pkg;
   localparam int PSR_W      = 32;
   localparam int MODE_W     = 5;
   localparam int NBANK      = 5;
   localparam int BANK_IDX_W = 3;

   localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
   localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
   localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
   localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
   localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
   localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;

   localparam logic [BANK_IDX_W-1:0] BANK_FIQ = 3'd0;
   localparam logic [BANK_IDX_W-1:0] BANK_IRQ = 3'd1;
   localparam logic [BANK_IDX_W-1:0] BANK_SVC = 3'd2;
   localparam logic [BANK_IDX_W-1:0] BANK_ABT = 3'd3;
   localparam logic [BANK_IDX_W-1:0] BANK_UND = 3'd4;
   localparam logic [BANK_IDX_W-1:0] NO_BANK  = 3'd7;

   typedef enum logic [2:0] {
      EXC_NONE = 3'd0,
      EXC_RST  = 3'd1,
      EXC_UND  = 3'd2,
      EXC_TRAP = 3'd3,
      EXC_PABT = 3'd4,
      EXC_DABT = 3'd5,
      EXC_IRQ  = 3'd6,
      EXC_FIQ  = 3'd7
   } exc_e;

   // word-spaced handler addresses; 0x14 is left unused
   function automatic logic [7:0] exc_vector(exc_e e);
      case (e)
         EXC_UND:  return 8'h04;
         EXC_TRAP: return 8'h08;
         EXC_PABT: return 8'h0C;
         EXC_DABT: return 8'h10;
         EXC_IRQ:  return 8'h18;
         EXC_FIQ:  return 8'h1C;
         default:  return 8'h00;
      endcase
   endfunction

   function automatic logic [MODE_W-1:0] exc_mode(exc_e e);
      case (e)
         EXC_UND:  return MODE_UND;
         EXC_PABT: return MODE_ABT;
         EXC_DABT: return MODE_ABT;
         EXC_IRQ:  return MODE_IRQ;
         EXC_FIQ:  return MODE_FIQ;
         default:  return MODE_SVC;
      endcase
   endfunction

   function automatic logic [BANK_IDX_W-1:0] mode_bank(logic [MODE_W-1:0] m);
      case (m)
         MODE_FIQ: return BANK_FIQ;
         MODE_IRQ: return BANK_IRQ;
         MODE_SVC: return BANK_SVC;
         MODE_ABT: return BANK_ABT;
         MODE_UND: return BANK_UND;
         default:  return NO_BANK;
      endcase
   endfunction
endpackage

// File: rtl/exc_seq_trapdec.sv
`timescale 1ns/1ps
module exc_seq_trapdec #(
   parameter int NUM_W = 24
) (
   input  logic             valid_i,
   input  logic [NUM_W+3:0] bits_i,
   output logic             hit_o,
   output logic [NUM_W-1:0] num_o
);
   localparam int OPC_LO = NUM_W;
   localparam int OPC_HI = NUM_W + 3;

   if (NUM_W < 1) begin : g_chk_num
      $error("exc_seq_trapdec: NUM_W must be positive");
   end

   assign hit_o = valid_i && (bits_i[OPC_HI:OPC_LO] == 4'hF);
   assign num_o = bits_i[NUM_W-1:0];
endmodule

// File: rtl/exc_seq_prio.sv
`timescale 1ns/1ps
module exc_seq_prio
   import exc_seq_pkg::*;
(
   input  logic rst_req_i,
   input  logic dabt_req_i,
   input  logic fiq_req_i,
   input  logic irq_req_i,
   input  logic pabt_req_i,
   input  logic und_req_i,
   input  logic trap_hit_i,
   input  logic fiq_mask_i,
   input  logic irq_mask_i,
   output exc_e sel_o
);
   always_comb begin
      if (rst_req_i)                       sel_o = EXC_RST;
      else if (dabt_req_i)                 sel_o = EXC_DABT;
      else if (fiq_req_i && !fiq_mask_i)   sel_o = EXC_FIQ;
      else if (irq_req_i && !irq_mask_i)   sel_o = EXC_IRQ;
      else if (pabt_req_i)                 sel_o = EXC_PABT;
      else if (und_req_i)                  sel_o = EXC_UND;
      else if (trap_hit_i)                 sel_o = EXC_TRAP;
      else                                 sel_o = EXC_NONE;
   end
endmodule

// File: rtl/exc_seq_bank.sv
`timescale 1ns/1ps
module exc_seq_bank #(
   parameter int             AW      = 32,
   parameter int             PW      = 32,
   parameter logic [PW-1:0]  PSR_RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [AW-1:0] lr_d_i,
   input  logic [PW-1:0] psr_d_i,
   output logic [AW-1:0] lr_q_o,
   output logic [PW-1:0] psr_q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_q_o  <= '0;
         psr_q_o <= PSR_RST;
      end else if (wr_i) begin
         lr_q_o  <= lr_d_i;
         psr_q_o <= psr_d_i;
      end
   end

   p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> ($stable(lr_q_o) && $stable(psr_q_o)));
endmodule

// File: rtl/exc_seq.sv
`timescale 1ns/1ps
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int AW            = 32,
   parameter int IBIT          = 7,
   parameter int FBIT          = 6,
   parameter int TRAP_NUM_W    = 24,
   parameter bit TRAP_NUM_HOLD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rst_req_i,
   input  logic                    und_req_i,
   input  logic                    pabt_req_i,
   input  logic                    dabt_req_i,
   input  logic                    irq_req_i,
   input  logic                    fiq_req_i,
   input  logic                    insn_valid_i,
   input  logic [TRAP_NUM_W+3:0]   insn_bits_i,
   input  logic                    ret_req_i,
   output logic [AW-1:0]           pc_o,
   output logic [PSR_W-1:0]        psr_o,
   output logic [NBANK*AW-1:0]     lr_bank_o,
   output logic [NBANK*PSR_W-1:0]  spsr_bank_o,
   output logic [TRAP_NUM_W-1:0]   trap_num_o
);
   localparam logic [PSR_W-1:0] PSR_AT_RST =
      PSR_W'(MODE_SVC) | (PSR_W'(1) << IBIT) | (PSR_W'(1) << FBIT);
   localparam logic [PSR_W-1:0] SPSR_AT_RST = PSR_W'(MODE_USR);
   localparam logic [AW-1:0]    WORD_STEP   = AW'(4);

   if (AW < 8) begin : g_chk_aw
      $error("exc_seq: AW must hold the vector map");
   end
   if (IBIT < MODE_W || IBIT >= PSR_W || FBIT < MODE_W || FBIT >= PSR_W) begin : g_chk_bits
      $error("exc_seq: mask bits must lie above the mode field");
   end
   if (IBIT == FBIT) begin : g_chk_same
      $error("exc_seq: mask bits must differ");
   end

   logic [AW-1:0]           pc_q, pc_d, pc_next_seq, lr_cur;
   logic [PSR_W-1:0]        psr_q, psr_d, spsr_cur;
   logic                    trap_hit, ret_ok;
   logic [TRAP_NUM_W-1:0]   trap_num;
   exc_e                    sel;
   logic [BANK_IDX_W-1:0]   cur_bank, tgt_bank;
   logic [NBANK-1:0]        bank_wr;
   logic [AW-1:0]           lr_q   [NBANK];
   logic [PSR_W-1:0]        spsr_q [NBANK];

   exc_seq_trapdec #(.NUM_W(TRAP_NUM_W)) u_dec (
      .valid_i (insn_valid_i),
      .bits_i  (insn_bits_i),
      .hit_o   (trap_hit),
      .num_o   (trap_num)
   );

   exc_seq_prio u_prio (
      .rst_req_i  (rst_req_i),
      .dabt_req_i (dabt_req_i),
      .fiq_req_i  (fiq_req_i),
      .irq_req_i  (irq_req_i),
      .pabt_req_i (pabt_req_i),
      .und_req_i  (und_req_i),
      .trap_hit_i (trap_hit),
      .fiq_mask_i (psr_q[FBIT]),
      .irq_mask_i (psr_q[IBIT]),
      .sel_o      (sel)
   );

   assign pc_next_seq = pc_q + WORD_STEP;
   assign cur_bank    = mode_bank(psr_q[MODE_W-1:0]);
   assign tgt_bank    = mode_bank(exc_mode(sel));
   assign ret_ok      = ret_req_i && (cur_bank != NO_BANK);

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_wr[g] = (sel != EXC_NONE) && (sel != EXC_RST) &&
                          (tgt_bank == BANK_IDX_W'(g));
      exc_seq_bank #(.AW(AW), .PW(PSR_W), .PSR_RST(SPSR_AT_RST)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (bank_wr[g]),
         .lr_d_i  (pc_next_seq),
         .psr_d_i (psr_q),
         .lr_q_o  (lr_q[g]),
         .psr_q_o (spsr_q[g])
      );
      assign lr_bank_o[g*AW +: AW]         = lr_q[g];
      assign spsr_bank_o[g*PSR_W +: PSR_W] = spsr_q[g];
   end

   always_comb begin
      lr_cur   = '0;
      spsr_cur = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (cur_bank == BANK_IDX_W'(b)) begin
            lr_cur   = lr_q[b];
            spsr_cur = spsr_q[b];
         end
      end
   end

   always_comb begin
      pc_d  = pc_q;
      psr_d = psr_q;
      if (sel != EXC_NONE) begin
         pc_d                 = AW'(exc_vector(sel));
         psr_d[MODE_W-1:0]    = exc_mode(sel);
         psr_d[IBIT]          = 1'b1;
         if (sel == EXC_FIQ || sel == EXC_RST) psr_d[FBIT] = 1'b1;
      end else if (ret_ok) begin
         pc_d  = lr_cur;
         psr_d = spsr_cur;
      end else if (insn_valid_i && !ret_req_i) begin
         pc_d  = pc_next_seq;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         psr_q <= PSR_AT_RST;
      end else begin
         pc_q  <= {pc_d[AW-1:2], 2'b00};
         psr_q <= psr_d;
      end
   end

   if (TRAP_NUM_HOLD) begin : g_tn_hold
      logic [TRAP_NUM_W-1:0] tn_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               tn_q <= '0;
         else if (sel == EXC_TRAP) tn_q <= trap_num;
      end
      assign trap_num_o = tn_q;
   end else begin : g_tn_live
      assign trap_num_o = trap_num;
   end

   assign pc_o  = pc_q;
   assign psr_o = psr_q;

   p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      psr_q[IBIT] |-> (sel != EXC_IRQ));
   p_fiq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      psr_q[FBIT] |-> (sel != EXC_FIQ));
   p_rst_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_i |=> (pc_q == '0 && psr_q[MODE_W-1:0] == MODE_SVC &&
                     psr_q[IBIT] && psr_q[FBIT]));
   p_trap_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EXC_TRAP) |=> (pc_q == AW'(8) && psr_q[MODE_W-1:0] == MODE_SVC &&
                             psr_q[IBIT]));
   p_svc_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EXC_TRAP) |=> (lr_q[BANK_SVC] == $past(pc_q) + WORD_STEP &&
                             spsr_q[BANK_SVC] == $past(psr_q)));
   p_ret_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_ok && sel == EXC_NONE) |=> (psr_q == $past(spsr_cur) &&
                                       pc_q == ($past(lr_cur) & ~AW'(3))));
   p_ret_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_req_i && sel == EXC_NONE && psr_q[MODE_W-1:0] == MODE_USR)
         |=> ($stable(psr_q) && $stable(pc_q)));
   p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bank(psr_q[MODE_W-1:0]) != NO_BANK) || (psr_q[MODE_W-1:0] == MODE_USR));
endmodule

// File: tb/exc_seq_bench.sv
`timescale 1ns/1ps
module exc_seq_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rst_req = 0, und_req = 0, pabt_req = 0, dabt_req = 0;
   logic         irq_req = 0, fiq_req = 0, insn_valid = 0, ret_req = 0;
   logic [27:0]  insn_bits = '0;
   logic [31:0]  pc_o, psr_o;
   logic [159:0] lr_bank_o, spsr_bank_o;
   logic [23:0]  trap_num_o;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] e_pc, e_psr;
   logic [31:0] e_lr [5];
   logic [31:0] e_spsr [5];
   logic [23:0] e_tn;

   always #2.5 clk = ~clk;

   exc_seq u_exc_seq (
      .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req), .und_req_i(und_req),
      .pabt_req_i(pabt_req), .dabt_req_i(dabt_req), .irq_req_i(irq_req),
      .fiq_req_i(fiq_req), .insn_valid_i(insn_valid), .insn_bits_i(insn_bits),
      .ret_req_i(ret_req), .pc_o(pc_o), .psr_o(psr_o), .lr_bank_o(lr_bank_o),
      .spsr_bank_o(spsr_bank_o), .trap_num_o(trap_num_o)
   );

   function automatic int bidx(logic [4:0] m);
      case (m)
         5'b10001: return 0;
         5'b10010: return 1;
         5'b10011: return 2;
         5'b10111: return 3;
         5'b11011: return 4;
         default:  return -1;
      endcase
   endfunction

   task automatic check(string what, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic compare(string tag);
      check({tag, " pc"}, pc_o, e_pc);
      check({tag, "/R5 status"}, psr_o, e_psr);
      check("R12 pc low bits", {30'b0, pc_o[1:0]}, 32'h0);
      for (int b = 0; b < 5; b++) begin
         check({tag, "/R4/R11 link bank"}, lr_bank_o[b*32 +: 32], e_lr[b]);
         check({tag, "/R4/R11 saved status bank"}, spsr_bank_o[b*32 +: 32], e_spsr[b]);
      end
      check("R3 trap number", {8'h0, trap_num_o}, {8'h0, e_tn});
   endtask

   task automatic hard_reset();
      rst_req = 0; und_req = 0; pabt_req = 0; dabt_req = 0;
      irq_req = 0; fiq_req = 0; insn_valid = 0; ret_req = 0; insn_bits = '0;
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      e_pc = 32'h0; e_psr = 32'h0000_00D3; e_tn = '0;
      for (int b = 0; b < 5; b++) begin e_lr[b] = 32'h0; e_spsr[b] = 32'h10; end
      compare("R1");
      rst_n = 1'b1;
   endtask

   task automatic step(logic r, logic u, logic pa, logic da, logic iq, logic fq,
                       logic iv, logic [27:0] ib, logic rt);
      int    sel, npend, b, vec;
      logic  sw, fmask, imask;
      logic [4:0] md;
      string tag;
      rst_req = r; und_req = u; pabt_req = pa; dabt_req = da;
      irq_req = iq; fiq_req = fq; insn_valid = iv; insn_bits = ib; ret_req = rt;
      sw    = iv && (ib[27:24] == 4'hF);
      fmask = e_psr[6];
      imask = e_psr[7];
      // R6 order: reset, data abort, fast irq, irq, prefetch abort, undefined, trap
      if (r)                  sel = 1;
      else if (da)            sel = 5;
      else if (fq && !fmask)  sel = 7;
      else if (iq && !imask)  sel = 6;
      else if (pa)            sel = 4;
      else if (u)             sel = 2;
      else if (sw)            sel = 3;
      else                    sel = 0;
      npend = int'(r) + int'(da) + int'(fq && !fmask) + int'(iq && !imask) +
              int'(pa) + int'(u) + int'(sw);
      if (sel == 0) begin
         b = bidx(e_psr[4:0]);
         if (rt && b >= 0) begin
            tag = "R8";
            e_pc  = e_lr[b] & ~32'h3;
            e_psr = e_spsr[b];
         end else if (rt) begin
            tag = "R9";
         end else begin
            tag = "R10";
            if (iv) e_pc = e_pc + 32'd4;
         end
         if ((iq && imask) || (fq && fmask)) tag = {tag, "/R7"};
      end else begin
         case (sel)
            1: begin vec = 0;  md = 5'b10011; end
            2: begin vec = 4;  md = 5'b11011; end
            3: begin vec = 8;  md = 5'b10011; end
            4: begin vec = 12; md = 5'b10111; end
            5: begin vec = 16; md = 5'b10111; end
            6: begin vec = 24; md = 5'b10010; end
            default: begin vec = 28; md = 5'b10001; end
         endcase
         tag = (sel == 3) ? "R3" : "R2";
         if (npend > 1) tag = {tag, "/R6"};
         if ((iq && imask) || (fq && fmask)) tag = {tag, "/R7"};
         if (sel != 1) begin
            b = bidx(md);
            e_lr[b]   = e_pc + 32'd4;
            e_spsr[b] = e_psr;
         end
         e_psr[4:0] = md;
         e_psr[7]   = 1'b1;
         if (sel == 1 || sel == 7) e_psr[6] = 1'b1;
         e_pc = 32'(vec);
         if (sel == 3) e_tn = ib[23:0];
      end
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [27:0] ib;
      hard_reset();
      // R10: sequential advance and idle hold
      step(0,0,0,0,0,0, 1, 28'h0A1_2345, 0);
      step(0,0,0,0,0,0, 1, 28'h0A1_2345, 0);
      step(0,0,0,0,0,0, 0, 28'h0, 0);
      // R8 from supervisor, then R9 user-mode return with a valid instruction
      step(0,0,0,0,0,0, 0, 28'h0, 1);
      step(0,0,0,0,0,0, 1, 28'h0, 1);
      // R3 trap from user, nested irq blocked by mask, return chain
      step(0,0,0,0,0,0, 1, 28'hF_ABCDEF, 0);
      step(0,0,0,0,1,0, 1, 28'h1_000000, 0);
      step(0,0,0,0,0,0, 0, 28'h0, 1);
      // near-exhaustive sweep over request combinations from three states
      for (int base = 0; base < 3; base++) begin
         for (int c = 0; c < 128; c++) begin
            hard_reset();
            if (base >= 1) step(0,0,0,0,0,0, 0, 28'h0, 1);
            if (base == 2) step(0,0,0,0,1,0, 0, 28'h0, 0);
            ib = {(c[6] ? 4'hF : 4'hE), 24'(c * 24'h01_0203) ^ 24'hA5C35A};
            step(c[0], c[1], c[2], c[3], c[4], c[5], 1'b1, ib, 1'b0);
            step(0,0,0,0,0,0, 0, 28'h0, 1);
            step(0,0,0,0,0,0, 1, 28'h0, 1);
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule